// File: doc/BRIEF.md
# Serial Frame Multiplexer with Alignment Marker

This block builds a serial time-division frame out of several parallel byte channels. Software or upstream logic writes one byte per channel into staging registers at any time. On each frame tick, which is typically an 8 kHz strobe that opens a 125 µs frame, the block copies all staged bytes into holding registers. It then drives a frame onto a single serial line, one bit per clock.

A frame is a sequence of fixed slots, each `SLOT_W` bits wide. Slot 0 always carries a constant alignment marker. Slots 1 to `N_CH` carry channel 0 to channel `N_CH-1` in ascending order. A receiver can therefore find slot boundaries from the serial data alone and needs no separate sync wire. The block also gives a one-cycle frame-start pulse and the index of the slot currently on the line. Between frames the line rests high.

With the defaults (4 channels, 8-bit slots) a frame is 40 bit clocks long. A wider build, for example 31 channels plus the marker for a 32-slot frame, only changes the parameters.

Top module: `tdm_framer`

## Requirements
- R1: In reset and on the first cycle after it, `ser_out` is 1, `frame_start` is 0 and `slot_idx` is 0.
- R2: Until a frame tick is accepted, `ser_out` stays at 1 and `slot_idx` stays at 0 whatever is written to the channel registers.
- R3: A `frame_tick` sampled high while idle starts a frame on the next cycle. On that cycle `frame_start` is high, and it is high for that one cycle only.
- R4: Slot 0 carries the parameter `MARKER` (default 8'b10011011), most significant bit first. Its first bit is on the line in the same cycle as `frame_start`.
- R5: Slot c+1 carries the byte of channel c, most significant bit first, so the channels follow the marker in ascending order and each slot holds exactly one channel.
- R6: `slot_idx` equals the number of the slot whose bit is on `ser_out`. It holds for `SLOT_W` clocks and then steps by one, running from 0 to `N_CH`.
- R7: The frame sends the staged values as they were on the clock edge that accepted the tick. A write on that same cycle or later in the frame shows up only in the next frame.
- R8: A `frame_tick` that arrives during a frame is ignored, except on the frame's last bit.
- R9: A `frame_tick` on the last bit of a frame starts the next frame directly, with no idle bit between the two frames.
- R10: When a frame ends and no tick is accepted, `ser_out` goes back to 1 and `slot_idx` goes back to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Request to start a frame |
| wr_en | input | 1 | Write strobe for a channel staging register |
| wr_ch | input | $clog2(N_CH) | Channel number to write |
| wr_data | input | SLOT_W | Byte to stage for that channel |
| ser_out | output | 1 | Serial frame data, idle high |
| frame_start | output | 1 | High on the first marker bit of each frame |
| slot_idx | output | $clog2(N_CH+1) | Slot number of the bit now on ser_out |

## Verification
The bench writes different bytes to every channel and then walks whole frames bit by bit. A design that sends LSB first, swaps channels, or moves a slot boundary by one bit produces a wrong bit in the stream. It rewrites channels in the middle of a frame and on the tick cycle itself, which catches a design that reads the staging registers directly instead of the captured copy. It also sends ticks in the middle of a frame and exactly on the last bit. A counter that restarts mid-frame, or one that inserts an idle bit before a back-to-back frame, shifts the whole expected stream. Idle periods before the first frame and after the last frame confirm that the line rests high and that the slot index parks at 0.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned DEF_N_CH   = 4;
  localparam int unsigned DEF_SLOT_W = 8;
  localparam logic [7:0]  DEF_MARKER = 8'b10011011;
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int unsigned N_SLOTS = 5,
  parameter int unsigned SLOT_W  = 8,
  localparam int unsigned BW = $clog2(SLOT_W),
  localparam int unsigned SW = $clog2(N_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic          busy,
  output logic [SW-1:0] slot_idx,
  output logic          frame_start,
  output logic          start,
  output logic          slot_end,
  output logic          frame_end
);
  logic [BW-1:0] bit_idx;

  always_comb begin
    slot_end  = busy && (bit_idx == BW'(SLOT_W - 1));
    frame_end = slot_end && (slot_idx == SW'(N_SLOTS - 1));
    start     = tick && (!busy || frame_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      bit_idx     <= '0;
      slot_idx    <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= start;
      if (start) begin
        busy     <= 1'b1;
        bit_idx  <= '0;
        slot_idx <= '0;
      end else if (busy) begin
        if (slot_end) begin
          bit_idx <= '0;
          if (frame_end) begin
            busy     <= 1'b0;
            slot_idx <= '0;
          end else begin
            slot_idx <= slot_idx + SW'(1);
          end
        end else begin
          bit_idx <= bit_idx + BW'(1);
        end
      end
    end
  end

  assert_fs_single_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  assert_fs_at_slot0_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (busy && slot_idx == '0 && bit_idx == '0));
  assert_slot_range_R6: assert property (@(posedge clk) disable iff (rst)
    slot_idx <= SW'(N_SLOTS - 1));
  assert_slot_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !slot_end) |=> $stable(slot_idx));
  assert_idle_slot0_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> slot_idx == '0);
endmodule

// File: rtl/tdm_chan_regs.sv
module tdm_chan_regs #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned SLOT_W = 8,
  localparam int unsigned CW = $clog2(N_CH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CW-1:0]                wr_ch,
  input  logic [SLOT_W-1:0]            wr_data,
  input  logic                         capture,
  output logic [N_CH-1:0][SLOT_W-1:0]  hold
);
  logic [N_CH-1:0][SLOT_W-1:0] stage;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[c] <= '0;
        hold[c]  <= '0;
      end else begin
        if (capture)
          hold[c] <= stage[c];
        if (wr_en && wr_ch == CW'(c))
          stage[c] <= wr_data;
      end
    end
  end

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> (hold == $past(stage)));
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(hold));
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned SLOT_W = 8,
  parameter logic [SLOT_W-1:0] MARKER = 8'b10011011,
  localparam int unsigned SW = $clog2(N_CH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        busy,
  input  logic                        slot_end,
  input  logic                        frame_end,
  input  logic                        frame_start,
  input  logic [SW-1:0]               slot_idx,
  input  logic [N_CH-1:0][SLOT_W-1:0] hold,
  output logic                        ser_out
);
  logic [SLOT_W-1:0] sr;
  logic [SLOT_W-1:0] nxt_byte;

  always_comb begin
    nxt_byte = '1;
    for (int c = 0; c < N_CH; c++)
      if (slot_idx == SW'(c))
        nxt_byte = hold[c];
  end

  always_ff @(posedge clk) begin
    if (rst)
      sr <= '1;
    else if (start)
      sr <= MARKER;
    else if (frame_end)
      sr <= '1;
    else if (slot_end)
      sr <= nxt_byte;
    else if (busy)
      sr <= {sr[SLOT_W-2:0], 1'b1};
  end

  assign ser_out = sr[SLOT_W-1];

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);
  assert_marker_msb_R4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (ser_out == MARKER[SLOT_W-1]));
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int unsigned N_CH   = DEF_N_CH,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  parameter logic [SLOT_W-1:0] MARKER = DEF_MARKER,
  localparam int unsigned CW = $clog2(N_CH),
  localparam int unsigned SW = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [SLOT_W-1:0] wr_data,
  output logic              ser_out,
  output logic              frame_start,
  output logic [SW-1:0]     slot_idx
);
  logic busy, start, slot_end, frame_end;
  logic [N_CH-1:0][SLOT_W-1:0] hold;

  tdm_slot_ctr #(.N_SLOTS(N_CH + 1), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst(rst), .tick(frame_tick), .busy(busy),
    .slot_idx(slot_idx), .frame_start(frame_start), .start(start),
    .slot_end(slot_end), .frame_end(frame_end)
  );

  tdm_chan_regs #(.N_CH(N_CH), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .capture(start), .hold(hold)
  );

  tdm_serializer #(.N_CH(N_CH), .SLOT_W(SLOT_W), .MARKER(MARKER)) u_ser (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .slot_end(slot_end), .frame_end(frame_end), .frame_start(frame_start),
    .slot_idx(slot_idx), .hold(hold), .ser_out(ser_out)
  );

  assert_midframe_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && busy && !frame_end) |=> !frame_start);
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && frame_end) |=> (frame_start && busy));
  assert_frame_over_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !frame_tick) |=> (ser_out && slot_idx == '0 && !busy));
endmodule

// File: tb/sim_tdm_framer.sv
module sim_tdm_framer;
  localparam int N_CH = 4;
  localparam int SW_B = 8;
  localparam int FL   = (N_CH + 1) * SW_B;
  localparam logic [7:0] MK = 8'b10011011;

  typedef struct {
    logic       s;
    logic       f;
    logic [2:0] slot;
    string      tag;
  } exp_t;

  logic clk = 0, rst = 1, frame_tick = 0, wr_en = 0;
  logic [1:0] wr_ch = 0;
  logic [7:0] wr_data = 0;
  logic ser_out, frame_start;
  logic [2:0] slot_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];

  // requirement-level model state
  bit m_busy = 0;
  int m_pos = 0;
  logic [7:0] m_stage [N_CH];
  logic [7:0] m_hold  [N_CH];

  tdm_framer u0 (.clk(clk), .rst(rst), .frame_tick(frame_tick), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_data(wr_data), .ser_out(ser_out),
    .frame_start(frame_start), .slot_idx(slot_idx));

  always #10 clk = ~clk;

  // monitor: compares each produced cycle with the scoreboard queue
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (ser_out !== e.s || frame_start !== e.f || slot_idx !== e.slot) begin
        n_bad++;
        $display("FAIL %s: got ser=%b fs=%b slot=%0d, expected ser=%b fs=%b slot=%0d",
                 e.tag, ser_out, frame_start, slot_idx, e.s, e.f, e.slot);
      end
    end
  end

  // driver: applies one cycle of inputs and pushes the expected result
  task automatic cyc(input bit tk, input bit we, input int ch, input logic [7:0] d,
                     input string tag);
    exp_t e;
    bit last, st;
    @(negedge clk);
    frame_tick = tk; wr_en = we; wr_ch = 2'(ch); wr_data = d;
    last = m_busy && (m_pos == FL - 1);
    st = tk && (!m_busy || last);
    if (st) begin
      for (int c = 0; c < N_CH; c++) m_hold[c] = m_stage[c];
      m_busy = 1; m_pos = 0;
    end else if (m_busy) begin
      if (last) begin m_busy = 0; m_pos = 0; end
      else m_pos++;
    end
    if (we) m_stage[ch] = d;
    e.tag = tag;
    if (m_busy) begin
      int sl, bi;
      logic [7:0] by;
      sl = m_pos / SW_B; bi = m_pos % SW_B;
      by = (sl == 0) ? MK : m_hold[sl-1];
      e.s = by[7-bi]; e.f = st; e.slot = 3'(sl);
    end else begin
      e.s = 1'b1; e.f = 1'b0; e.slot = 3'd0;
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, tag);
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) begin m_stage[c] = 0; m_hold[c] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    n_chk++;
    if (ser_out !== 1'b1 || frame_start !== 1'b0 || slot_idx !== 3'd0) begin
      n_bad++;
      $display("FAIL R1: got ser=%b fs=%b slot=%0d, expected 1 0 0", ser_out, frame_start, slot_idx);
    end
    rst = 0;
    idle(3, "R1 R2 idle after reset");
    // R2: writes while idle leave the line high
    cyc(0, 1, 0, 8'hA5, "R2 write while idle");
    cyc(0, 1, 1, 8'h3C, "R2 write while idle");
    cyc(0, 1, 2, 8'hF0, "R2 write while idle");
    cyc(0, 1, 3, 8'h0E, "R2 write while idle");
    idle(2, "R2 idle");
    // R3 R4 R5 R6: first frame; R8 ticks mid-frame; R7 writes mid-frame
    cyc(1, 0, 0, 8'h00, "R3 R4 frame start");
    for (int i = 1; i < FL; i++) begin
      if (i == 5 || i == 17 || i == 30) cyc(1, 0, 0, 8'h00, "R8 mid-frame tick");
      else if (i == 12) cyc(0, 1, 0, 8'h11, "R7 mid-frame write");
      else if (i == 25) cyc(0, 1, 3, 8'h80, "R7 mid-frame write");
      else cyc(0, 0, 0, 8'h00, "R4 R5 R6 frame bits");
    end
    idle(4, "R10 return to idle");
    // R7: write on the tick cycle goes to the next frame
    cyc(1, 1, 1, 8'hC3, "R7 tick with write");
    for (int i = 1; i < FL; i++) cyc(0, 0, 0, 8'h00, "R5 R6 R7 second frame");
    // R9: tick on last bit of this frame chains frames
    cyc(1, 1, 2, 8'h5A, "R9 back-to-back start");
    for (int i = 1; i < FL; i++) cyc(0, 0, 0, 8'h00, "R9 chained frame");
    cyc(1, 0, 0, 8'h00, "R9 second chain");
    for (int i = 1; i < FL; i++) cyc(0, 0, 0, 8'h00, "R5 R9 chained frame");
    idle(6, "R10 final idle");
    @(negedge clk); @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule